// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fetches a device's power-up configuration from a 128-word by 16-bit serial EEPROM over a four-wire link. The link has chip select, serial clock, a command/data line toward the memory and a data line back from it. Each word is fetched in its own chip-select frame. The frame carries a start bit, a two-bit read opcode and an eight-bit word address, then a dummy bit and sixteen data bits. The loader reads words 0 through 26 in ascending order, which covers every byte up to and including the checksum byte.

Words sit in the memory with their bit order reversed. The loader flips each word back to natural order and splits it into two bytes, the low half first. It then drops the bytes into their fields: the station address, an ID field, fourteen bytes of control-register images and nineteen bytes of plug-and-play defaults. It also keeps a separate copy of the miscellaneous control word held at word 16. A running 8-bit sum checks the image, and a single-cycle done pulse marks the end of the load. A load starts on its own when reset is released, and a start strobe repeats it once the loader is idle.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, chip select, serial clock, done and the error flag are low and every field output is zero. After reset is released, frames are issued for word addresses 0 to 26 in ascending order, each exactly once, and no other address is read. Each frame sends the bits 1, 1, 0 followed by the eight address bits, MSB first.
- R2: The serial clock period is CLK_DIV system clocks with a 50% duty cycle. The command line changes only while the serial clock is low. Returned data is sampled on serial-clock rising edges: the first returned bit is a dummy and is discarded, and the 16 data bits that follow arrive MSB first.
- R3: Between frames, chip select is held low for at least CLK_DIV system clocks. The serial clock stays low whenever chip select is low.
- R4: Natural bit i of each word equals stored bit 15-i.
- R5: Natural word w supplies image byte 2w from bits 7:0 and byte 2w+1 from bits 15:8. The station address output holds image bytes 0 to 5, with byte k at bits 8k+7:8k.
- R6: The ID output holds bytes 16 to 19, the control-image output holds bytes 20 to 33 and the plug-and-play output holds bytes 34 to 52. Each uses the same packing as R5, with the first byte in the lowest bits.
- R7: The miscellaneous control output equals natural word 16, which is image bytes 32 (low) and 33 (high).
- R8: The error flag is 0 when the 8-bit modulo sum of image bytes 0 to 53 equals 0xFF, and 1 otherwise. It takes its value together with the done pulse and holds it until the next load starts.
- R9: The done pulse is high for exactly one cycle. It comes one cycle after chip select falls at the end of the word-26 frame. After that, chip select stays low and no further done occurs until a new load starts.
- R10: A start strobe while the loader is idle begins a new load from address 0 and clears the error flag. A start strobe during a load is ignored: the address sequence carries on and only one done results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reload strobe, honoured only when idle |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Command bits toward the memory |
| ee_do_i | input | 1 | Data bits from the memory |
| mac_addr_o | output | 48 | Station address, bytes 0..5 |
| id_o | output | 32 | ID field, bytes 16..19 |
| ctrl_img_o | output | 112 | Control-register images, bytes 20..33 |
| misc_cfg_o | output | 16 | Miscellaneous control word (word 16) |
| pnp_dflt_o | output | 152 | Plug-and-play defaults, bytes 34..52 |
| done_o | output | 1 | One-cycle load-complete pulse |
| csum_err_o | output | 1 | Checksum error flag |

## Verification
A frame lasts 28 serial-clock periods, so every CLK_DIV system clocks the bench expects another rising edge, and it measures each interval against that value. The memory model checks the command and address of each frame at the eleventh rising edge, against addresses the driver has queued in order. Field values and the error flag are due in the same cycle as done, and done is due exactly one cycle after the final chip-select fall. The error flag must read clear from the second cycle after an accepted start. All outputs are sampled on the falling system-clock edge, so every registered change has settled and the expected cycle is counted exactly.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 8;
  localparam int IMG_BYTES = 54;            // bytes 0..53, checksum last
  localparam int NUM_WORDS = IMG_BYTES / 2;
  localparam int LAST_WORD = NUM_WORDS - 1;
  localparam int MISC_WORD = 16;

  localparam int MAC_OFS  = 0;
  localparam int MAC_B    = 6;
  localparam int ID_OFS   = 16;
  localparam int ID_B     = 4;
  localparam int CTRL_OFS = 20;
  localparam int CTRL_B   = 14;
  localparam int PNP_OFS  = 34;
  localparam int PNP_B    = 19;

  localparam logic [7:0] CSUM_OK = 8'hFF;

  typedef enum logic [1:0] {R_IDLE, R_GAP, R_SHIFT} rd_state_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

  function automatic logic [WORD_W-1:0] mirror_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/eep_serial_rd.sv
module eep_serial_rd #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  input  logic              do_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  import cfg_loader_pkg::*;

  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = $clog2(CLK_DIV + 1);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int FRAME = CMD_W + 1 + WORD_W;
  localparam int BIT_W = $clog2(FRAME + 1);

  rd_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  sh_out_q;
  logic [WORD_W-1:0] sh_in_q;

  assign ready_o = (st_q == R_IDLE);
  assign word_o  = sh_in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= R_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      sh_out_q   <= '0;
      sh_in_q    <= '0;
      cs_o       <= 1'b0;
      sk_o       <= 1'b0;
      di_o       <= 1'b0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      case (st_q)
        R_IDLE: if (req_i) begin
          sh_out_q <= {3'b110, addr_i};
          cnt_q    <= '0;
          st_q     <= R_GAP;
        end
        R_GAP: begin
          if (cnt_q == CNT_W'(CLK_DIV - 1)) begin
            cnt_q    <= '0;
            cs_o     <= 1'b1;
            di_o     <= sh_out_q[CMD_W-1];
            sh_out_q <= sh_out_q << 1;
            bit_q    <= '0;
            st_q     <= R_SHIFT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        R_SHIFT: begin
          if (cnt_q == CNT_W'(HALF - 1)) begin
            cnt_q <= '0;
            if (!sk_o) begin
              sk_o    <= 1'b1;
              sh_in_q <= {sh_in_q[WORD_W-2:0], do_i};
            end else begin
              sk_o <= 1'b0;
              if (bit_q == BIT_W'(FRAME - 1)) begin
                cs_o       <= 1'b0;
                di_o       <= 1'b0;
                word_vld_o <= 1'b1;
                st_q       <= R_IDLE;
              end else begin
                bit_q    <= bit_q + 1'b1;
                di_o     <= sh_out_q[CMD_W-1];
                sh_out_q <= sh_out_q << 1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  // cycles spent with chip select low, saturating
  logic [CNT_W-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              low_cnt_q <= '0;
    else if (cs_o)                            low_cnt_q <= '0;
    else if (low_cnt_q != CNT_W'(CLK_DIV))    low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_sk_low_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sk_o);
  assert_cs_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (low_cnt_q >= CNT_W'(CLK_DIV)));
  assert_di_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && sk_o && $past(sk_o)) |-> $stable(di_o));
  assert_vld_at_cs_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $fell(cs_o));
endmodule

// File: rtl/cfg_unpack.sv
module cfg_unpack
  import cfg_loader_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wvld_i,
  input  logic [ADDR_W-1:0]     widx_i,
  input  logic [WORD_W-1:0]     wraw_i,
  output logic [MAC_B*8-1:0]    mac_o,
  output logic [ID_B*8-1:0]     id_o,
  output logic [CTRL_B*8-1:0]   ctrl_o,
  output logic [PNP_B*8-1:0]    pnp_o,
  output logic [WORD_W-1:0]     misc_o,
  output logic                  done_o,
  output logic                  csum_err_o
);
  logic [WORD_W-1:0] nat;
  logic [7:0]        sum_q, sum_base, sum_nx;
  logic [7:0]        byte_q [IMG_BYTES];
  logic              last_w;

  assign nat      = mirror_word(wraw_i);
  assign sum_base = (widx_i == '0) ? 8'h00 : sum_q;
  assign sum_nx   = sum_base + nat[7:0] + nat[15:8];
  assign last_w   = wvld_i && (widx_i == ADDR_W'(LAST_WORD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < IMG_BYTES; k++) byte_q[k] <= '0;
    end else if (wvld_i) begin
      for (int k = 0; k < IMG_BYTES; k++)
        if (widx_i == ADDR_W'(k / 2))
          byte_q[k] <= (k % 2 == 1) ? nat[15:8] : nat[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q      <= '0;
      misc_o     <= '0;
      done_o     <= 1'b0;
      csum_err_o <= 1'b0;
    end else begin
      done_o <= last_w;
      if (wvld_i) sum_q <= sum_nx;
      if (wvld_i && widx_i == ADDR_W'(MISC_WORD)) misc_o <= nat;
      if (clr_i)       csum_err_o <= 1'b0;
      else if (last_w) csum_err_o <= (sum_nx != CSUM_OK);
    end
  end

  for (genvar k = 0; k < MAC_B; k++) begin : g_mac
    assign mac_o[8*k +: 8] = byte_q[MAC_OFS+k];
  end
  for (genvar k = 0; k < ID_B; k++) begin : g_id
    assign id_o[8*k +: 8] = byte_q[ID_OFS+k];
  end
  for (genvar k = 0; k < CTRL_B; k++) begin : g_ctrl
    assign ctrl_o[8*k +: 8] = byte_q[CTRL_OFS+k];
  end
  for (genvar k = 0; k < PNP_B; k++) begin : g_pnp
    assign pnp_o[8*k +: 8] = byte_q[PNP_OFS+k];
  end

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(csum_err_o) |-> (done_o || $past(clr_i)));
  assert_misc_in_ctrl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (misc_o == ctrl_o[(2*MISC_WORD-CTRL_OFS)*8 +: WORD_W]));
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_loader_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           ee_cs_o,
  output logic           ee_sk_o,
  output logic           ee_di_o,
  input  logic           ee_do_i,
  output logic [47:0]    mac_addr_o,
  output logic [31:0]    id_o,
  output logic [111:0]   ctrl_img_o,
  output logic [15:0]    misc_cfg_o,
  output logic [151:0]   pnp_dflt_o,
  output logic           done_o,
  output logic           csum_err_o
);
  seq_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_ready, rd_vld, clr;
  logic [WORD_W-1:0] rd_word;

  assign clr = (st_q == S_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_ISSUE;
      addr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          addr_q <= '0;
          st_q   <= S_ISSUE;
        end
        S_ISSUE: if (rd_ready) st_q <= S_WAIT;
        S_WAIT: if (rd_vld) begin
          if (addr_q == ADDR_W'(LAST_WORD)) st_q <= S_IDLE;
          else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= S_ISSUE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  eep_serial_rd #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (st_q == S_ISSUE),
    .addr_i     (addr_q),
    .ready_o    (rd_ready),
    .cs_o       (ee_cs_o),
    .sk_o       (ee_sk_o),
    .di_o       (ee_di_o),
    .do_i       (ee_do_i),
    .word_vld_o (rd_vld),
    .word_o     (rd_word)
  );

  cfg_unpack u_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .wvld_i     (rd_vld),
    .widx_i     (addr_q),
    .wraw_i     (rd_word),
    .mac_o      (mac_addr_o),
    .id_o       (id_o),
    .ctrl_o     (ctrl_img_o),
    .pnp_o      (pnp_dflt_o),
    .misc_o     (misc_cfg_o),
    .done_o     (done_o),
    .csum_err_o (csum_err_o)
  );

  assert_addr_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= ADDR_W'(LAST_WORD));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q != S_IDLE && addr_q != '0) |=> (addr_q != '0));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !start_i) |=> !ee_cs_o);
endmodule

// File: tb/cfg_eeprom_loader_bench.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_bench;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic cs, sk, di, do_r;
  logic [47:0] mac; logic [31:0] id; logic [111:0] ctrl;
  logic [15:0] misc; logic [151:0] pnp; logic done, err;

  always #4 clk = ~clk;

  cfg_eeprom_loader #(.CLK_DIV(CLK_DIV)) u_cfg_eeprom_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(do_r),
    .mac_addr_o(mac), .id_o(id), .ctrl_img_o(ctrl), .misc_cfg_o(misc),
    .pnp_dflt_o(pnp), .done_o(done), .csum_err_o(err));

  typedef struct packed {
    logic [47:0] mac; logic [31:0] id; logic [111:0] ctrl;
    logic [15:0] misc; logic [151:0] pnp; logic err;
  } exp_t;

  exp_t exp_q[$];
  int   addr_q[$];
  logic [15:0] mem [128];
  int checks = 0, fails = 0, n_done = 0, cyc = 0, viol = 0;

  task automatic chk(input bit ok, input string tag, input logic [151:0] act, input logic [151:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[15-i];
    return r;
  endfunction

  // driver: fills memory, queues expected addresses and fields
  task automatic build_image(input int seed, input bit good);
    logic [7:0] b [56];
    logic [7:0] sum;
    exp_t e;
    sum = 8'h00;
    for (int k = 0; k < 56; k++) begin
      b[k] = 8'(seed * 29 + k * k * 7 + k * 13 + (seed << (k % 5)));
      if (k < 53) sum = sum + b[k];
    end
    b[53] = good ? 8'(8'hFF - sum) : 8'(8'hFE - sum);
    for (int w = 0; w < 128; w++)
      mem[w] = (w < 28) ? {b[2*w+1], b[2*w]} : (16'hA5A5 ^ 16'(w));
    for (int k = 0; k < 6;  k++) e.mac[8*k +: 8]  = b[k];
    for (int k = 0; k < 4;  k++) e.id[8*k +: 8]   = b[16+k];
    for (int k = 0; k < 14; k++) e.ctrl[8*k +: 8] = b[20+k];
    for (int k = 0; k < 19; k++) e.pnp[8*k +: 8]  = b[34+k];
    e.misc = {b[33], b[32]};
    e.err  = !good;
    exp_q.push_back(e);
    for (int a = 0; a < 27; a++) addr_q.push_back(a);
  endtask

  // EEPROM model: stores words mirrored
  int rise_n = 0;
  logic [10:0] cmd = '0;
  logic [7:0]  cur_a = '0;
  initial do_r = 1'b0;

  always @(posedge cs) rise_n = 0;

  always @(posedge sk) if (cs) begin
    rise_n++;
    if (rise_n <= 11) cmd = {cmd[9:0], di};
    if (rise_n == 11) begin
      int ea;
      cur_a = cmd[7:0];
      chk(cmd[10:8] == 3'b110, "R1 command bits", 152'(cmd[10:8]), 152'(3'b110));
      ea = (addr_q.size() > 0) ? addr_q.pop_front() : -1;
      chk(int'(cmd[7:0]) == ea, "R1 word address", 152'(cmd[7:0]), 152'(ea));
    end
  end

  always @(negedge sk) if (cs) begin
    logic [15:0] sw;
    sw = rev16(mem[cur_a]);
    if (rise_n == 11) do_r = 1'b1;  // dummy slot: must be discarded (R2)
    else if (rise_n >= 12 && rise_n <= 27) do_r = sw[27-rise_n];
  end

  // monitor: timing, scoreboard pop on done
  logic p_sk = 0, p_di = 0, p_cs = 0, p_done = 0, seen_rise = 0;
  int since_rise = 0, low_cnt = 0, cs_fall_cyc = -10;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (cs && sk && p_sk && di != p_di) viol++;
      if (!cs && sk) viol++;
      since_rise++;
      if (sk && !p_sk) begin
        if (seen_rise) chk(since_rise == CLK_DIV, "R2 sk period", 152'(since_rise), 152'(CLK_DIV));
        since_rise = 0;
        seen_rise = 1;
      end
      if (!cs) low_cnt++;
      if (cs && !p_cs) begin
        chk(low_cnt >= CLK_DIV, "R3 cs gap", 152'(low_cnt), 152'(CLK_DIV));
        low_cnt = 0;
      end
      if (!cs && p_cs) begin
        cs_fall_cyc = cyc;
        seen_rise = 0;
      end
      if (done) begin
        n_done++;
        chk(!p_done, "R9 done width", 152'(p_done), 152'(0));
        chk(cyc - cs_fall_cyc == 1, "R9 done timing", 152'(cyc - cs_fall_cyc), 152'(1));
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", 152'(1), 152'(0));
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(mac == e.mac,   "R5 station address", 152'(mac),  152'(e.mac));
          chk(id == e.id,     "R6 id field",        152'(id),   152'(e.id));
          chk(ctrl == e.ctrl, "R6 control images",  152'(ctrl), 152'(e.ctrl));
          chk(pnp == e.pnp,   "R6 pnp defaults",    pnp,        e.pnp);
          chk(misc == e.misc, "R7 R4 misc word",    152'(misc), 152'(e.misc));
          chk(err == e.err,   "R8 checksum flag",   152'(err),  152'(e.err));
        end
      end
    end
    p_sk = sk; p_di = di; p_cs = cs; p_done = done;
  end

  task automatic wait_done();
    int d0;
    d0 = n_done;
    while (n_done == d0) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    int d0; bit quiet; bit held;
    build_image(1, 1'b1);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cs && !sk && !done && !err, "R1 reset controls", 152'({cs, sk, done, err}), 152'(0));
    chk(mac == 0 && pnp == 0 && misc == 0, "R1 reset fields", 152'(mac), 152'(0));
    rst_n = 1'b1;
    wait_done();
    repeat (2) @(negedge clk);
    chk(addr_q.size() == 0, "R1 all 27 words read", 152'(addr_q.size()), 152'(0));
    // R9 idle after done
    quiet = 1;
    d0 = n_done;
    repeat (100) begin @(negedge clk); if (cs) quiet = 0; end
    chk(quiet && n_done == d0, "R9 idle after done", 152'(quiet), 152'(1));

    // R8 bad checksum, flag held
    build_image(2, 1'b0);
    pulse_start();
    wait_done();
    held = 1;
    repeat (40) begin @(negedge clk); if (!err) held = 0; end
    chk(held, "R8 error held", 152'(held), 152'(1));

    // R10 clear on start, start ignored mid-load
    build_image(3, 1'b1);
    pulse_start();
    @(negedge clk);
    chk(!err, "R10 error cleared", 152'(err), 152'(0));
    repeat (600) @(negedge clk);
    d0 = n_done;
    pulse_start();
    wait_done();
    repeat (300) @(negedge clk);
    chk(n_done == d0 + 1, "R10 start ignored while busy", 152'(n_done - d0), 152'(1));
    chk(addr_q.size() == 0, "R10 address sequence intact", 152'(addr_q.size()), 152'(0));

    // reload after idle with a fourth image
    build_image(4, 1'b1);
    pulse_start();
    wait_done();
    repeat (5) @(negedge clk);
    chk(viol == 0, "R2 R3 di/sk discipline", 152'(viol), 152'(0));
    chk(exp_q.size() == 0, "R9 every load completed", 152'(exp_q.size()), 152'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule